// File: doc/BRIEF.md
# Shortened Reed-Solomon Two-Byte Parity Encoder

This block appends two check bytes to a stream of data bytes so that each resulting codeword is a shortened Reed-Solomon codeword over GF(2^8). Two code lengths are supported and chosen per codeword: a short one with 24 data bytes and a long one with 43 data bytes. Each codeword carries two parity bytes, which gives totals of 26 and 45 bytes. These are the row and column check codes of a byte-matrix product code.

Bytes arrive with valid, first and last flags and come out one cycle later, unchanged. After the last data byte, the block stalls its input for two cycles and emits the two parity bytes. Only the real data bytes enter the division register. The shortened positions are never padded with zeros. A length selector is sampled with the first byte of each codeword. A codeword whose last byte arrives at the wrong count is flagged and gets no parity.

Top module: `rs_parity_enc`

## Requirements
- R1: Arithmetic uses GF(2^8) reduced by x^8+x^4+x^3+x^2+1 (0x11D), with α = 0x02. A complete codeword c(x), whose first byte is the highest power, is divisible by (x+1)(x+α). This means both the XOR of all bytes and the sum of each byte times α^(n-1-i) are zero.
- R2: With `in_mode`=0 at the first byte, a codeword is 24 data bytes followed by 2 parity bytes.
- R3: With `in_mode`=1 at the first byte, a codeword is 43 data bytes followed by 2 parity bytes.
- R4: Every accepted data byte appears on `out_data` exactly one cycle later, unchanged, with `out_parity`=0. `out_first` repeats `in_first`.
- R5: The parity bytes follow the last data byte in consecutive cycles. The x^1 coefficient comes first and the x^0 coefficient second. Both carry `out_parity`=1, and only the second carries `out_last`=1.
- R6: The division register restarts at each first byte. An unfinished earlier codeword does not affect the next parity.
- R7: `in_ready` is low in exactly the two cycles in which the parity bytes are being produced.
- R8: `in_mode` is ignored on every byte except the first byte of a codeword.
- R9: If the last byte arrives at a count other than the selected length, then three things happen. `len_err` pulses together with that byte's output. That byte carries `out_last`=1. No parity bytes follow.
- R10: During reset and until the internal reset release, `out_valid`, `len_err` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_first | input | 1 | First data byte of a codeword |
| in_last | input | 1 | Last data byte of a codeword |
| in_mode | input | 1 | Length select: 0 = 24 data bytes, 1 = 43 data bytes |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Data or parity byte |
| out_first | output | 1 | First byte of codeword |
| out_last | output | 1 | Last byte of codeword (or of an errored one) |
| out_parity | output | 1 | Output byte is a parity byte |
| len_err | output | 1 | Length mismatch on the byte now shown |

## Verification
The bench sweeps every nonzero byte value through one position, and a single 0x01 through every position of both lengths. These sweeps expose a wrong field constant, a wrong generator coefficient or an off-by-one power: any of those gives parity that fails the two root equations. Pseudo-random codewords alternate the length and toggle the selector on middle bytes, so a design that resamples the mode would expect the wrong length. Deliberately short, long and abandoned codewords check two things: that mismatches are flagged without parity, and that a restart clears the register. A design that forgets to clear would leave stale residue in the next parity.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int SYM_W = 8;

  typedef enum logic [1:0] {
    ST_DATA   = 2'd0,
    ST_PAR_HI = 2'd1,
    ST_PAR_LO = 2'd2
  } rsp_state_e;
endpackage

// File: rtl/rsp_rst_sync.sv
module rsp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/rsp_gf_cmul.sv
// Multiply a field element by a fixed constant: XOR of a*alpha^i for set bits.
module rsp_gf_cmul #(
  parameter int               SYM_W = 8,
  parameter logic [SYM_W:0]   POLY  = 9'h11D,
  parameter logic [SYM_W-1:0] CONST = 8'h02
) (
  input  logic [SYM_W-1:0] a,
  output logic [SYM_W-1:0] p
);
  logic [SYM_W-1:0] pw   [SYM_W];
  logic [SYM_W-1:0] term [SYM_W];

  assign pw[0] = a;

  genvar gi;
  generate
    for (gi = 1; gi < SYM_W; gi++) begin : g_pow
      assign pw[gi] = {pw[gi-1][SYM_W-2:0], 1'b0}
                    ^ ({SYM_W{pw[gi-1][SYM_W-1]}} & POLY[SYM_W-1:0]);
    end
    for (gi = 0; gi < SYM_W; gi++) begin : g_term
      if (CONST[gi]) begin : g_on
        assign term[gi] = pw[gi];
      end else begin : g_off
        assign term[gi] = '0;
      end
    end
  endgenerate

  always_comb begin
    p = '0;
    for (int i = 0; i < SYM_W; i++) p = p ^ term[i];
  end
endmodule

// File: rtl/rsp_parity_lfsr.sv
// Two-stage division register for g(x) = x^2 + G1*x + G0.
module rsp_parity_lfsr #(
  parameter int               SYM_W = 8,
  parameter logic [SYM_W:0]   POLY  = 9'h11D,
  parameter logic [SYM_W-1:0] G1    = 8'h03,
  parameter logic [SYM_W-1:0] G0    = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             restart,
  input  logic [SYM_W-1:0] din,
  output logic [SYM_W-1:0] r_hi,
  output logic [SYM_W-1:0] r_lo
);
  logic [SYM_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic [SYM_W-1:0] fb, prev_lo, fb_g1, fb_g0;

  assign fb      = din ^ (restart ? '0 : hi_q);
  assign prev_lo = restart ? '0 : lo_q;

  rsp_gf_cmul #(.SYM_W(SYM_W), .POLY(POLY), .CONST(G1)) u_m1 (.a(fb), .p(fb_g1));
  rsp_gf_cmul #(.SYM_W(SYM_W), .POLY(POLY), .CONST(G0)) u_m0 (.a(fb), .p(fb_g0));

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (shift_en) begin
      hi_d = prev_lo ^ fb_g1;
      lo_d = fb_g0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign r_hi = hi_q;
  assign r_lo = lo_q;
endmodule

// File: rtl/rsp_frame_ctrl.sv
module rsp_frame_ctrl
  import rsp_pkg::*;
#(
  parameter int SHORT_LEN = 24,
  parameter int LONG_LEN  = 43,
  localparam int CNT_W    = $clog2(LONG_LEN + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       live,
  input  logic       in_valid,
  input  logic       in_first,
  input  logic       in_last,
  input  logic       in_mode,
  output logic       in_ready,
  output logic       accept,
  output logic       restart,
  output logic       len_bad,
  output rsp_state_e state
);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LEN);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  rsp_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             mode_q, mode_d, mode_eff;
  logic [CNT_W-1:0] target;
  logic             len_match;

  assign in_ready = live && (st_q == ST_DATA);
  assign accept   = in_ready && in_valid;
  assign restart  = accept && in_first;

  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign mode_eff  = in_first ? in_mode : mode_q;
  assign target    = mode_eff ? LONG_C : SHORT_C;
  assign len_match = ((in_first ? CNT_W'(1) : cnt_inc) == target);
  assign len_bad   = accept && in_last && !len_match;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (accept) begin
      cnt_d = in_first ? CNT_W'(1) : cnt_inc;
      if (in_first) mode_d = in_mode;
    end
    case (st_q)
      ST_DATA:   if (accept && in_last && len_match) st_d = ST_PAR_HI;
      ST_PAR_HI: st_d = ST_PAR_LO;
      ST_PAR_LO: st_d = ST_DATA;
      default:   st_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_DATA;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/rs_parity_enc.sv
module rs_parity_enc
  import rsp_pkg::*;
#(
  parameter int             SHORT_LEN = 24,
  parameter int             LONG_LEN  = 43,
  parameter logic [SYM_W:0] POLY      = 9'h11D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic             in_mode,
  input  logic [SYM_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_first,
  output logic             out_last,
  output logic             out_parity,
  output logic             len_err
);
  logic             rst_core_n;
  logic             accept, restart, len_bad;
  rsp_state_e       state;
  logic [SYM_W-1:0] r_hi, r_lo;

  logic             vld_d, fst_d, lst_d, par_d, err_d;
  logic [SYM_W-1:0] dat_d;

  rsp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  rsp_frame_ctrl #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .live(rst_core_n),
    .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
    .in_mode(in_mode), .in_ready(in_ready), .accept(accept),
    .restart(restart), .len_bad(len_bad), .state(state)
  );

  rsp_parity_lfsr #(.SYM_W(SYM_W), .POLY(POLY), .G1(8'h03), .G0(8'h02)) u_lfsr (
    .clk(clk), .rst_n(rst_core_n), .shift_en(accept), .restart(restart),
    .din(in_data), .r_hi(r_hi), .r_lo(r_lo)
  );

  always_comb begin
    vld_d = 1'b0;
    fst_d = 1'b0;
    lst_d = 1'b0;
    par_d = 1'b0;
    err_d = 1'b0;
    dat_d = out_data;
    if (accept) begin
      vld_d = 1'b1;
      dat_d = in_data;
      fst_d = in_first;
      lst_d = len_bad;
      err_d = len_bad;
    end else if (state == ST_PAR_HI) begin
      vld_d = 1'b1;
      dat_d = r_hi;
      par_d = 1'b1;
    end else if (state == ST_PAR_LO) begin
      vld_d = 1'b1;
      dat_d = r_lo;
      par_d = 1'b1;
      lst_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      out_parity <= 1'b0;
      len_err    <= 1'b0;
    end else begin
      out_valid  <= vld_d;
      out_data   <= dat_d;
      out_first  <= fst_d;
      out_last   <= lst_d;
      out_parity <= par_d;
      len_err    <= err_d;
    end
  end
endmodule

// File: rtl/rsp_enc_chk.sv
module rsp_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_parity,
  input logic       len_err
);
  // R4
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && !out_parity && out_data == $past(in_data));

  // R5
  parity_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_parity && !out_last |=> out_valid && out_parity && out_last);

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_parity && !out_last |-> !in_ready);

  // R9
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> out_valid && out_last && !out_parity);

  // R9
  err_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> !out_parity);
endmodule

bind rs_parity_enc rsp_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_last(out_last), .out_parity(out_parity), .len_err(len_err)
);

// File: tb/sim_rs_parity_enc.sv
`timescale 1ns/1ps
module sim_rs_parity_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_mode = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, out_first, out_last, out_parity, len_err;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] buff [64];
  logic [7:0] cap_d [64];
  logic       cap_l [64], cap_p [64], cap_f [64];
  int         cap_n = 0, err_cnt = 0;
  bit         ready_bad = 0, ready_lo_bad = 0;
  int         seed = 32'h1234_5678;
  logic [7:0] inv3;

  always #2 clk = ~clk;

  rs_parity_enc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_mode(in_mode), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .out_parity(out_parity),
    .len_err(len_err)
  );

  always @(negedge clk) begin
    if (out_valid && cap_n < 64) begin
      cap_d[cap_n] = out_data; cap_l[cap_n] = out_last;
      cap_p[cap_n] = out_parity; cap_f[cap_n] = out_first;
      cap_n++;
    end
    if (len_err) err_cnt++;
    if (out_parity && !out_last && in_ready) ready_bad = 1;
    if (out_parity && out_last && !in_ready) ready_lo_bad = 1;
  end

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic f, input logic l, input logic m);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_first = f; in_last = l; in_mode = m;
    @(posedge clk); #1;
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  // Sends n bytes of buff with length select m; flip toggles in_mode on non-first bytes (R8)
  task automatic run_frame(input logic m, input int n, input bit flip);
    int  k;
    bit  ok_len;
    logic [7:0] s0, s1, ap, p1, p0;
    repeat (3) @(negedge clk);
    cap_n = 0; err_cnt = 0; ready_bad = 0; ready_lo_bad = 0;
    for (int i = 0; i < n; i++)
      put(buff[i], i == 0, i == n - 1, (i == 0) ? m : (flip ? ~m : m));
    repeat (5) @(negedge clk);
    k = m ? 43 : 24;
    ok_len = (n == k);
    for (int i = 0; i < n; i++)
      chk(cap_d[i] == buff[i] && !cap_p[i] && cap_f[i] == (i == 0), "R4", "data passthrough",
          cap_d[i], buff[i]);
    if (ok_len) begin
      s0 = 0; s1 = 0;
      for (int i = 0; i < n; i++) begin
        ap = 8'h01;
        for (int e = 0; e < n + 1 - i; e++) ap = gm(ap, 8'h02);
        s0 = s0 ^ buff[i];
        s1 = s1 ^ gm(buff[i], ap);
      end
      p1 = gm(s0 ^ s1, inv3);
      p0 = s0 ^ p1;
      chk(cap_n == n + 2 && err_cnt == 0, m ? "R3" : "R2", "codeword length", cap_n, n + 2);
      chk(cap_d[n] == p1, "R1", "parity x^1", cap_d[n], p1);
      chk(cap_d[n+1] == p0, "R1", "parity x^0", cap_d[n+1], p0);
      chk(cap_p[n] && cap_p[n+1] && !cap_l[n] && cap_l[n+1] && !cap_l[n-1], "R5",
          "parity flags", {cap_p[n], cap_p[n+1], cap_l[n], cap_l[n+1]}, 4'b1101);
      chk(!ready_bad && !ready_lo_bad, "R7", "ready during parity",
          {ready_bad, ready_lo_bad}, 0);
    end else begin
      chk(cap_n == n, "R9", "no parity on length error", cap_n, n);
      chk(err_cnt == 1 && cap_l[n-1], "R9", "error flag and last", err_cnt, 1);
    end
  endtask

  function automatic logic [7:0] rnd();
    seed = seed * 1103515245 + 12345;
    return seed[23:16];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    inv3 = 0;
    for (int v = 1; v < 256; v++) if (gm(8'(v), 8'h03) == 8'h01) inv3 = 8'(v);

    repeat (3) @(negedge clk);
    // R10
    chk(!out_valid && !len_err && !in_ready, "R10", "in reset",
        {out_valid, len_err, in_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !in_ready, "R10", "sync release pending", {out_valid, in_ready}, 0);
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready && !len_err, "R10", "after release",
        {out_valid, in_ready, len_err}, 3'b010);

    // R1 R2: all zero and all ones
    for (int i = 0; i < 64; i++) buff[i] = 8'h00;
    run_frame(0, 24, 0);
    for (int i = 0; i < 64; i++) buff[i] = 8'hFF;
    run_frame(0, 24, 0);
    run_frame(1, 43, 0);

    // R1: every value in the first position
    for (int v = 1; v < 256; v++) begin
      for (int i = 0; i < 64; i++) buff[i] = 8'h00;
      buff[0] = 8'(v);
      run_frame(0, 24, 0);
    end
    // R2 R3: single 0x01 in every position
    for (int p = 0; p < 24; p++) begin
      for (int i = 0; i < 64; i++) buff[i] = 8'h00;
      buff[p] = 8'h01;
      run_frame(0, 24, 0);
    end
    for (int p = 0; p < 43; p++) begin
      for (int i = 0; i < 64; i++) buff[i] = 8'h00;
      buff[p] = 8'h01;
      run_frame(1, 43, 0);
    end

    // R8: random frames, mode toggled on non-first bytes
    for (int f = 0; f < 200; f++) begin
      for (int i = 0; i < 64; i++) buff[i] = rnd();
      run_frame(f[0], f[0] ? 43 : 24, f[1]);
    end

    // R9: wrong lengths
    for (int i = 0; i < 64; i++) buff[i] = rnd();
    run_frame(0, 23, 0);
    run_frame(0, 25, 0);
    run_frame(1, 24, 0);
    run_frame(0, 43, 0);
    run_frame(1, 44, 0);
    run_frame(0, 1, 0);

    // R6: abandoned frame, then a fresh one
    for (int i = 0; i < 10; i++) put(rnd(), i == 0, 1'b0, 1'b1);
    for (int i = 0; i < 64; i++) buff[i] = rnd();
    run_frame(0, 24, 0);
    chk(cap_f[0] && cap_n == 26, "R6", "restart after abandoned frame", cap_n, 26);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule